// File: doc/BRIEF.md
# Supply-to-Battery Switchover Controller

This block decides, one voltage sample at a time, whether the device runs from its main supply or from its backup battery. It takes the main-supply and battery voltages as millivolt numbers, together with a strobe that marks a new valid sample. It applies one of two hysteretic switching policies, chosen by a policy input. The analog comparators and the power switches are outside the block. The block outputs a registered backup flag that drives them.

The block also protects the serial bus after a brownout. In a qualifying brownout the supply sags below the trip level but never below a floor level, then climbs back slowly. After such an event the bus is held disabled for a fixed number of millisecond ticks. Separately, while the block is in backup, a control input decides whether the bus may run at all.

Samples are expected at one per millisecond tick, so the ramp rate is the rise between two consecutive valid samples. The policy input is set to 1 (legacy) by the owner of that control bit at reset.

Top module: `pwr_switchover`

## Requirements
- R1: After reset, `on_battery` is 0 and `bus_en` is 1.
- R2: With `legacy_sel` = 0 (standard policy), backup is entered on a sample only if the supply is below both battery minus 50 mV and 2200 mV.
- R3: With `legacy_sel` = 0, backup is left on a sample where the supply is above battery plus 50 mV, or above 2230 mV.
- R4: With `legacy_sel` = 1 (legacy policy), backup is entered when the supply is below battery minus 50 mV. It is left when the supply is above battery plus 50 mV. The trip level plays no part.
- R5: `on_battery` changes only in the cycle after a clock edge at which `sample_vld` is 1.
- R6: A lockout starts when three things hold. The supply has fallen below 2200 mV without any sample under 1000 mV. It has then risen above 2230 mV. Every rise between consecutive samples during the dip was at most 250 mV. `bus_en` is then 0 from the next cycle and stays 0 for 90 ticks of `ms_tick`, returning to 1 after the 90th tick.
- R7: If any rise between consecutive samples during the dip exceeds 250 mV, recovery starts no lockout.
- R8: A sample below 1000 mV cancels the dip, and the next recovery above 2230 mV starts no lockout.
- R9: While `on_battery` is 1 and no lockout runs, `bus_en` equals `bus_in_backup_en`. While `on_battery` is 0, that input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Strobe marking a new voltage sample pair |
| vdd_mv | input | W | Main supply voltage in mV |
| vbat_mv | input | W | Battery voltage in mV |
| legacy_sel | input | 1 | Policy select: 0 standard, 1 legacy |
| bus_in_backup_en | input | 1 | Allows the serial bus while in backup |
| ms_tick | input | 1 | One-cycle millisecond tick |
| on_battery | output | 1 | Device runs from the battery |
| bus_en | output | 1 | Serial bus enable |

## Verification
The bench probes the edges of each hysteresis band. A supply at 2220 mV stays in backup under the standard policy, because a design that left at the bare trip level would drop out there. A legacy design that checked the trip level would refuse backup at 3000 mV.

It drives a slow recovery and counts the lockout to the exact tick. An off-by-one counter would release one tick early or late.

It also drives two recoveries that must not start a lockout: one with a single 300 mV step and one that first fell under the floor. A design that kept the dip armed through these would spuriously block the bus.

Random walks of both voltages, with random policy and bus-in-backup bits, compare every sample against a bench model of the requirements.

// File: rtl/pwr_switchover.sv
module pwr_switchover #(
  parameter int W           = 13,
  parameter int TRIP_MV     = 2200,
  parameter int TRIP_HYS_MV = 30,
  parameter int BAT_HYS_MV  = 50,
  parameter int FLOOR_MV    = 1000,
  parameter int RAMP_MV     = 250,
  parameter int LOCK_MS     = 90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_vld,
  input  logic [W-1:0] vdd_mv,
  input  logic [W-1:0] vbat_mv,
  input  logic         legacy_sel,
  input  logic         bus_in_backup_en,
  input  logic         ms_tick,
  output logic         on_battery,
  output logic         bus_en
);
  localparam int CW = $clog2(LOCK_MS + 1);
  localparam logic [W:0] TRIP   = (W+1)'(TRIP_MV);
  localparam logic [W:0] TRIPHI = (W+1)'(TRIP_MV + TRIP_HYS_MV);
  localparam logic [W:0] BHYS   = (W+1)'(BAT_HYS_MV);
  localparam logic [W:0] FLOOR  = (W+1)'(FLOOR_MV);
  localparam logic [W:0] RAMP   = (W+1)'(RAMP_MV);
  localparam logic [CW-1:0] LOCK = CW'(LOCK_MS);

  typedef enum logic [1:0] {ST_OK, ST_DIP, ST_DEAD} dip_t;

  dip_t          st;
  logic          fast;
  logic [W-1:0]  prev;
  logic [CW-1:0] lock_cnt;

  wire [W:0] vdd  = {1'b0, vdd_mv};
  wire [W:0] bat  = {1'b0, vbat_mv};
  wire [W:0] pv   = {1'b0, prev};

  wire below_bat  = (vdd + BHYS) < bat;
  wire above_bat  = vdd > (bat + BHYS);
  wire below_trip = vdd < TRIP;
  wire above_trip = vdd > TRIPHI;
  wire below_flr  = vdd < FLOOR;
  wire rise_fast  = (vdd > pv) && ((vdd - pv) > RAMP);

  wire enter = below_bat && (legacy_sel || below_trip);
  wire leave = above_bat || (!legacy_sel && above_trip);
  wire trig  = sample_vld && (st == ST_DIP) && !below_flr && above_trip && !(fast || rise_fast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_battery <= 1'b0;
    end else if (sample_vld) begin
      if (!on_battery && enter)     on_battery <= 1'b1;
      else if (on_battery && leave) on_battery <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OK;
      fast <= 1'b0;
      prev <= '0;
    end else if (sample_vld) begin
      prev <= vdd_mv;
      if (below_flr) begin
        st <= ST_DEAD;
      end else begin
        case (st)
          ST_OK:   if (below_trip) begin st <= ST_DIP; fast <= 1'b0; end
          ST_DIP:  if (above_trip) st <= ST_OK;
                   else fast <= fast | rise_fast;
          default: if (above_trip) st <= ST_OK;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lock_cnt <= '0;
    else if (trig)                      lock_cnt <= LOCK;
    else if (ms_tick && lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
  end

  assign bus_en = (lock_cnt == '0) && (!on_battery || bus_in_backup_en);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(on_battery));

  // R2
  std_no_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !legacy_sel && !on_battery && !below_trip) |=> !on_battery);

  // R4
  bat_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && on_battery && above_bat) |=> !on_battery);

  // R6
  lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !bus_en);

  // R6
  lock_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != '0 && ms_tick && !trig) |=> (lock_cnt == $past(lock_cnt) - 1'b1));

  // R8
  dead_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && below_flr) |=> (st == ST_DEAD));
endmodule

// File: tb/tb_pwr_switchover.sv
`timescale 1ns/1ps
module tb_pwr_switchover;
  localparam int W = 13;
  logic clk = 0, rst_n = 0, sample_vld = 0, legacy_sel = 0, bus_in_backup_en = 0, ms_tick = 0;
  logic [W-1:0] vdd_mv = '0, vbat_mv = '0;
  logic on_battery, bus_en;
  int checks = 0, fails = 0;
  int m_st = 0, m_prev = 0, m_cnt = 0;
  bit m_bat = 0, m_fast = 0;

  always #2.5 clk = ~clk;

  pwr_switchover #(.W(W)) dut (.clk, .rst_n, .sample_vld, .vdd_mv, .vbat_mv, .legacy_sel,
    .bus_in_backup_en, .ms_tick, .on_battery, .bus_en);

  function automatic bit f_enter(int v, int b, bit leg);
    return (v + 50 < b) && (leg || v < 2200);
  endfunction
  function automatic bit f_leave(int v, int b, bit leg);
    return (v > b + 50) || (!leg && v > 2230);
  endfunction
  function automatic bit f_bus(bit bib);
    return (m_cnt == 0) && (!m_bat || bib);
  endfunction

  task automatic model(int v, int b, bit leg);
    bit fn = m_fast || (v > m_prev && v - m_prev > 250);
    bit trig = 0;
    if (!m_bat && f_enter(v, b, leg)) m_bat = 1;
    else if (m_bat && f_leave(v, b, leg)) m_bat = 0;
    if (v < 1000) m_st = 2;
    else if (m_st == 0) begin if (v < 2200) begin m_st = 1; m_fast = 0; end end
    else if (m_st == 1) begin
      if (v > 2230) begin trig = !fn; m_st = 0; end else m_fast = fn;
    end else if (v > 2230) m_st = 0;
    if (trig) m_cnt = 90; else if (m_cnt > 0) m_cnt--;
    m_prev = v;
  endtask

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int v, int b, bit leg, bit bib, string req);
    @(negedge clk);
    vdd_mv = W'(v); vbat_mv = W'(b); legacy_sel = leg; bus_in_backup_en = bib;
    sample_vld = 1; ms_tick = 1;
    model(v, b, leg);
    @(negedge clk);
    sample_vld = 0; ms_tick = 0;
    chk(on_battery, m_bat, req);
    chk(bus_en, f_bus(bib), req);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1;
      if (m_cnt > 0) m_cnt--;
      @(negedge clk); ms_tick = 0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, b;
    bit leg, bib;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(on_battery, 0, "R1");
    chk(bus_en, 1, "R1");

    // R2 / R3 standard policy band edges
    step(3300, 3000, 0, 1, "R2");
    step(2300, 3000, 0, 1, "R2");
    chk(on_battery, 0, "R2 above trip");
    step(2100, 3000, 0, 1, "R2");
    chk(on_battery, 1, "R2 enter");
    step(2220, 3000, 0, 1, "R3");
    chk(on_battery, 1, "R3 inside trip hysteresis");
    step(2240, 3000, 0, 1, "R3");
    chk(on_battery, 0, "R3 leave");
    ticks(100);

    // R4 legacy policy
    step(2960, 3000, 1, 1, "R4");
    chk(on_battery, 0, "R4 inside band");
    step(2940, 3000, 1, 1, "R4");
    chk(on_battery, 1, "R4 enter");
    step(3040, 3000, 1, 1, "R4");
    chk(on_battery, 1, "R4 hold");
    step(3060, 3000, 1, 1, "R4");
    chk(on_battery, 0, "R4 leave");

    // R9 bus gating in backup
    step(3000, 3300, 1, 0, "R9");
    chk(bus_en, 0, "R9 blocked in backup");
    step(3000, 3300, 1, 1, "R9");
    chk(bus_en, 1, "R9 allowed in backup");

    // R5 no change without a strobe
    @(negedge clk); vdd_mv = W'(4000);
    @(negedge clk); @(negedge clk);
    chk(on_battery, 1, "R5");
    step(3400, 3300, 1, 0, "R9");
    chk(bus_en, 1, "R9 ignored off backup");

    // R6 slow recovery lockout
    step(3300, 1500, 0, 1, "R6");
    step(2000, 1500, 0, 1, "R6");
    step(2200, 1500, 0, 1, "R6");
    step(2400, 1500, 0, 1, "R6");
    chk(bus_en, 0, "R6 lockout start");
    ticks(89);
    chk(bus_en, 0, "R6 lockout before last tick");
    ticks(1);
    chk(bus_en, 1, "R6 lockout end");

    // R7 fast step
    step(3300, 1500, 0, 1, "R7");
    step(2000, 1500, 0, 1, "R7");
    step(2300, 1500, 0, 1, "R7");
    step(2400, 1500, 0, 1, "R7");
    chk(bus_en, 1, "R7 no lockout");

    // R8 below floor
    step(3300, 1500, 0, 1, "R8");
    step(900, 1500, 0, 1, "R8");
    for (int x = 1100; x <= 2500; x += 200) step(x, 1500, 0, 1, "R8");
    chk(bus_en, 1, "R8 no lockout");
    ticks(100);

    // random walks
    v = 3000; b = 3000; leg = 1; bib = 1;
    for (int i = 0; i < 1500; i++) begin
      if (i % 32 == 0) begin leg = $urandom_range(0, 1); bib = $urandom_range(0, 1); end
      if ($urandom_range(0, 9) == 0) v = $urandom_range(0, 4000);
      else v = v + int'($urandom_range(0, 600)) - 300;
      if (v < 0) v = 0;
      if (v > 4500) v = 4500;
      b = b + int'($urandom_range(0, 100)) - 50;
      if (b < 1800) b = 1800;
      if (b > 3600) b = 3600;
      step(v, b, leg, bib, leg ? "R4 R9 random" : "R2 R3 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule